// File: doc/BRIEF.md
# Non-Isochronous Endpoint Packet FIFO with Status Flags

This block holds one byte-wide packet buffer for each non-isochronous USB device endpoint. For every endpoint it tracks three conditions: whether the buffer is armed for the next transaction, whether it is empty, and whether it is full. The packet engine side pushes bytes into a buffer, pops bytes out of it, and reports the end of each transaction together with its handshake. The CPU side selects one endpoint at a time. It can arm the selected buffer, flush it, or reset it through single-cycle strobes, and it reads the selected endpoint's flags through a combinational status word.

The arm flag on each endpoint is a two-state machine with states `EN_OFF` and `EN_ARMED`. There are three transitions:
- `arm`: `EN_OFF` to `EN_ARMED`, taken on the set-enable strobe.
- `handshake-complete`: `EN_ARMED` to `EN_OFF`, taken when a transaction on that endpoint finishes with ACK or STALL.
- `endpoint-reset`: `EN_ARMED` to `EN_OFF`, taken on the reset-endpoint strobe.

When several of these events hit in the same cycle, the endpoint reset wins over arm, and arm wins over handshake completion. The set-up buffer has no flags of its own and is treated as always enabled. Selecting it returns an all-zero status word.

Top module: `ep_fifo_status`

## Requirements
- R1: After reset every endpoint reads with enable 0, empty 1, full 0 and error 0, so the status word is 0x0002.
- R2: The status word places full at bit 0, empty at bit 1, enable at bit 2 and the sticky error at bit 3. Bits 15 to 4 read as zero.
- R3: An `arm_stb` while a non-set-up endpoint is selected sets that endpoint's enable flag on the next clock edge.
- R4: `eng_done` with `eng_hs` equal to 2'b01 (ACK) or 2'b11 (STALL) clears the enable flag of endpoint `eng_ep` on the next edge. `eng_hs` equal to 2'b10 (NAK) or 2'b00 (no handshake) leaves the flag unchanged.
- R5: Full is set once a buffer holds DEPTH bytes (64 by default). A single pop clears it.
- R6: Bytes leave a buffer in the order they were pushed. `eng_pop_data` shows the head byte of endpoint `eng_ep` before the pop edge, and empty is set once the last byte has been popped.
- R7: `clr_stb` on the selected endpoint empties its buffer in one cycle, clears its error bit and leaves its enable flag unchanged.
- R8: `rst_ep_stb` on the selected endpoint empties its buffer, clears its error bit and clears its enable flag in one cycle.
- R9: A push into a full buffer and a pop from an empty buffer are both ignored and set the endpoint's sticky error bit (bit 3). The error bit stays set until a flush.
- R10: While `sel_valid` is low, `rd_data` is zero, and `rd_err` follows `rd_stb`.
- R11: While `sel_setup` is high with `sel_valid` high, `rd_data` is zero, `rd_err` is low, and the CPU strobes do not act on any endpoint.
- R12: Pushes, pops and strobes aimed at one endpoint leave the flags and contents of the other endpoints unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | CPU endpoint selection is valid |
| sel_setup | input | 1 | Selection targets the set-up buffer |
| sel_ep | input | 2 | Selected endpoint number |
| arm_stb | input | 1 | Set-enable strobe for the selected endpoint |
| clr_stb | input | 1 | Flush strobe for the selected endpoint, keeps enable |
| rst_ep_stb | input | 1 | Endpoint reset strobe, flushes and disarms |
| rd_stb | input | 1 | Status read strobe |
| rd_data | output | 16 | Status word of the selected endpoint |
| rd_err | output | 1 | Status read attempted without a valid selection |
| eng_ep | input | 2 | Endpoint addressed by the packet engine |
| eng_push | input | 1 | Push one byte |
| eng_push_data | input | 8 | Byte to push |
| eng_pop | input | 1 | Pop one byte |
| eng_pop_data | output | 8 | Head byte of the addressed endpoint |
| eng_done | input | 1 | Transaction on `eng_ep` completed this cycle |
| eng_hs | input | 2 | Handshake of the completed transaction |

## Verification
The hardest state to reach from the ports is a completely full buffer that then sees one more push. To get there, the stimulus pushes 64 bytes with a known pattern, attempts a 65th byte, and then drains all 64 bytes to confirm that the extra byte was never stored and that the error bit survived the drain. The arm machine's self-clearing path is reached by arming through the CPU side and then issuing completions from the engine side with each of the four handshake codes in turn. The NAK and no-handshake cases come first, so that a clear caused by the wrong code would be seen.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef enum logic {
        EN_OFF   = 1'b0,
        EN_ARMED = 1'b1
    } en_state_e;

    // Field order sets the bit positions of the status nibble (full at bit 0)
    typedef struct packed {
        logic err;
        logic enable;
        logic empty;
        logic full;
    } ep_flags_t;

    localparam int STAT_W = 16;

endpackage

// File: rtl/ep_arm_fsm.sv
module ep_arm_fsm
    import ep_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm_rst,
    input  logic term_hs,
    output logic enable
);

    en_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_OFF;
        else        state_q <= state_d;
    end

    // Priority: endpoint reset, then arm, then handshake completion
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_OFF: begin
                if (arm && !disarm_rst) state_d = EN_ARMED;
            end
            EN_ARMED: begin
                if (disarm_rst)           state_d = EN_OFF;
                else if (term_hs && !arm) state_d = EN_OFF;
            end
            default: state_d = EN_OFF;
        endcase
    end

    always_comb enable = (state_q == EN_ARMED);

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        arm && !disarm_rst |=> enable);                       // R3
    AST_TERM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        term_hs && !arm && !disarm_rst |=> !enable);          // R4
    AST_EPRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_rst |=> !enable);                              // R8

endmodule

// File: rtl/ep_fifo_store.sv
module ep_fifo_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          full,
    output logic          empty,
    output logic          err
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] OCC_MAX  = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ;
    logic          push_ok, pop_ok;

    always_comb begin
        full     = (occ == OCC_MAX);
        empty    = (occ == '0);
        push_ok  = push && !full && !flush;
        pop_ok   = pop && !empty && !flush;
        pop_data = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            err    <= 1'b0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            err    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
            if ((push && full) || (pop && empty)) err <= 1'b1;
        end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_MAX);                                      // R5
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));                                    // R5
    AST_FULL_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        full && pop && !push |=> !full);                      // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && !err);                             // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err && !flush |=> err);                               // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> full && err);      // R9

endmodule

// File: rtl/ep_stat_view.sv
module ep_stat_view
    import ep_fifo_pkg::*;
#(
    parameter int N_EP = 4,
    parameter int EPW  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_valid,
    input  logic                   sel_setup,
    input  logic [EPW-1:0]         sel_ep,
    input  logic                   rd_stb,
    input  ep_flags_t [N_EP-1:0]   flags,
    output logic [STAT_W-1:0]      rd_data,
    output logic                   rd_err
);

    always_comb begin
        rd_data = '0;
        rd_err  = 1'b0;
        if (!sel_valid) begin
            rd_err = rd_stb;
        end else if (!sel_setup) begin
            rd_data[3:0] = flags[sel_ep];
        end
    end

    AST_NOSEL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !sel_valid |-> rd_err && (rd_data == '0));  // R10
    AST_SETUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid && sel_setup |-> !rd_err && (rd_data == '0)); // R11
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[STAT_W-1:4] == '0);                           // R2

endmodule

// File: rtl/ep_fifo_status.sv
module ep_fifo_status
    import ep_fifo_pkg::*;
#(
    parameter int N_EP  = 4,
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int EPW   = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_valid,
    input  logic              sel_setup,
    input  logic [EPW-1:0]    sel_ep,
    input  logic              arm_stb,
    input  logic              clr_stb,
    input  logic              rst_ep_stb,
    input  logic              rd_stb,
    output logic [15:0]       rd_data,
    output logic              rd_err,
    input  logic [EPW-1:0]    eng_ep,
    input  logic              eng_push,
    input  logic [DW-1:0]     eng_push_data,
    input  logic              eng_pop,
    output logic [DW-1:0]     eng_pop_data,
    input  logic              eng_done,
    input  logic [1:0]        eng_hs
);

    logic                 cpu_hit;
    logic                 term_any;
    ep_flags_t [N_EP-1:0] flags;
    logic [DW-1:0]        head [N_EP];

    always_comb begin
        cpu_hit  = sel_valid && !sel_setup;
        term_any = eng_done && ((hs_e'(eng_hs) == HS_ACK) || (hs_e'(eng_hs) == HS_STALL));
    end

    for (genvar e = 0; e < N_EP; e++) begin : g_ep
        logic hit, eng_hit, flush;

        always_comb begin
            hit     = cpu_hit && (sel_ep == EPW'(e));
            eng_hit = (eng_ep == EPW'(e));
            flush   = hit && (clr_stb || rst_ep_stb);
        end

        ep_arm_fsm u_arm (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm        (hit && arm_stb),
            .disarm_rst (hit && rst_ep_stb),
            .term_hs    (eng_hit && term_any),
            .enable     (flags[e].enable)
        );

        ep_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .push      (eng_hit && eng_push),
            .push_data (eng_push_data),
            .pop       (eng_hit && eng_pop),
            .pop_data  (head[e]),
            .full      (flags[e].full),
            .empty     (flags[e].empty),
            .err       (flags[e].err)
        );
    end

    always_comb eng_pop_data = head[eng_ep];

    ep_stat_view #(.N_EP(N_EP), .EPW(EPW)) u_view (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_valid (sel_valid),
        .sel_setup (sel_setup),
        .sel_ep    (sel_ep),
        .rd_stb    (rd_stb),
        .flags     (flags),
        .rd_data   (rd_data),
        .rd_err    (rd_err)
    );

endmodule

// File: tb/ep_fifo_status_bench.sv
module ep_fifo_status_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_valid = 1'b0, sel_setup = 1'b0;
    logic [1:0]  sel_ep = '0;
    logic        arm_stb = 1'b0, clr_stb = 1'b0, rst_ep_stb = 1'b0, rd_stb = 1'b0;
    logic [15:0] rd_data;
    logic        rd_err;
    logic [1:0]  eng_ep = '0;
    logic        eng_push = 1'b0, eng_pop = 1'b0, eng_done = 1'b0;
    logic [7:0]  eng_push_data = '0;
    logic [7:0]  eng_pop_data;
    logic [1:0]  eng_hs = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ep_fifo_status u_ep_fifo_status (
        .clk(clk), .rst_n(rst_n),
        .sel_valid(sel_valid), .sel_setup(sel_setup), .sel_ep(sel_ep),
        .arm_stb(arm_stb), .clr_stb(clr_stb), .rst_ep_stb(rst_ep_stb),
        .rd_stb(rd_stb), .rd_data(rd_data), .rd_err(rd_err),
        .eng_ep(eng_ep), .eng_push(eng_push), .eng_push_data(eng_push_data),
        .eng_pop(eng_pop), .eng_pop_data(eng_pop_data),
        .eng_done(eng_done), .eng_hs(eng_hs)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic read_ep(input logic [1:0] ep, output logic [15:0] val);
        sel_valid = 1'b1; sel_setup = 1'b0; sel_ep = ep; rd_stb = 1'b1;
        #1;
        val = rd_data;
        rd_stb = 1'b0; sel_valid = 1'b0;
    endtask

    task automatic cpu_strobe(input logic [1:0] ep, input logic a, input logic c, input logic r);
        sel_valid = 1'b1; sel_setup = 1'b0; sel_ep = ep;
        arm_stb = a; clr_stb = c; rst_ep_stb = r;
        tick();
        arm_stb = 1'b0; clr_stb = 1'b0; rst_ep_stb = 1'b0; sel_valid = 1'b0;
    endtask

    task automatic push_byte(input logic [1:0] ep, input logic [7:0] d);
        eng_ep = ep; eng_push = 1'b1; eng_push_data = d;
        tick();
        eng_push = 1'b0;
    endtask

    task automatic pop_byte(input logic [1:0] ep, output logic [7:0] d);
        eng_ep = ep; eng_pop = 1'b1;
        #1;
        d = eng_pop_data;
        tick();
        eng_pop = 1'b0;
    endtask

    task automatic complete(input logic [1:0] ep, input logic [1:0] hs);
        eng_ep = ep; eng_done = 1'b1; eng_hs = hs;
        tick();
        eng_done = 1'b0; eng_hs = 2'b00;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        for (int e = 0; e < 4; e++) begin
            read_ep(2'(e), v);
            check($sformatf("R1 reset status ep%0d", e), v, 16'h0002);
        end
    endtask

    task automatic t_arm_and_handshakes();
        logic [15:0] v;
        cpu_strobe(2'd1, 1'b1, 1'b0, 1'b0);
        read_ep(2'd1, v); check("R3 arm sets enable (R2 bit 2)", v, 16'h0006);
        complete(2'd1, 2'b10);
        read_ep(2'd1, v); check("R4 NAK keeps enable", v, 16'h0006);
        complete(2'd1, 2'b00);
        read_ep(2'd1, v); check("R4 no handshake keeps enable", v, 16'h0006);
        complete(2'd0, 2'b01);
        read_ep(2'd1, v); check("R12 ACK on other ep keeps enable", v, 16'h0006);
        complete(2'd1, 2'b01);
        read_ep(2'd1, v); check("R4 ACK clears enable", v, 16'h0002);
        cpu_strobe(2'd1, 1'b1, 1'b0, 1'b0);
        complete(2'd1, 2'b11);
        read_ep(2'd1, v); check("R4 STALL clears enable", v, 16'h0002);
    endtask

    task automatic t_fill_and_drain();
        logic [15:0] v;
        logic [7:0]  d;
        for (int i = 0; i < 63; i++) push_byte(2'd2, 8'(i * 3 + 5));
        read_ep(2'd2, v); check("R5 63 bytes not full", v, 16'h0000);
        push_byte(2'd2, 8'(63 * 3 + 5));
        read_ep(2'd2, v); check("R5 64 bytes full (R2 bit 0)", v, 16'h0001);
        read_ep(2'd0, v); check("R12 other ep still empty", v, 16'h0002);
        push_byte(2'd2, 8'hEE);
        read_ep(2'd2, v); check("R9 push when full sets error", v, 16'h0009);
        pop_byte(2'd2, d);
        check("R6 first byte out", {8'h00, d}, {8'h00, 8'd5});
        read_ep(2'd2, v); check("R5 one pop clears full", v, 16'h0008);
        for (int i = 1; i < 64; i++) begin
            pop_byte(2'd2, d);
            if (d !== 8'(i * 3 + 5))
                check($sformatf("R6 byte order %0d", i), {8'h00, d}, {8'h00, 8'(i * 3 + 5)});
        end
        check("R6 last byte out", {8'h00, d}, {8'h00, 8'(63 * 3 + 5)});
        read_ep(2'd2, v); check("R9 extra byte not stored, error sticky", v, 16'h000A);
    endtask

    task automatic t_underflow_and_flush();
        logic [15:0] v;
        logic [7:0]  d;
        pop_byte(2'd3, d);
        read_ep(2'd3, v); check("R9 pop when empty sets error", v, 16'h000A);
        push_byte(2'd3, 8'h11);
        read_ep(2'd3, v); check("R9 error stays after push", v, 16'h0008);
        cpu_strobe(2'd3, 1'b1, 1'b0, 1'b0);
        cpu_strobe(2'd3, 1'b0, 1'b1, 1'b0);
        read_ep(2'd3, v); check("R7 clear empties, keeps enable, drops error", v, 16'h0006);
        push_byte(2'd3, 8'h22);
        push_byte(2'd3, 8'h33);
        cpu_strobe(2'd3, 1'b0, 1'b0, 1'b1);
        read_ep(2'd3, v); check("R8 endpoint reset empties and disarms", v, 16'h0002);
    endtask

    task automatic t_select_rules();
        logic [15:0] v;
        sel_valid = 1'b0; rd_stb = 1'b1;
        #1;
        check("R10 no select gives zero", rd_data, 16'h0000);
        check("R10 no select flags error", {15'd0, rd_err}, 16'h0001);
        rd_stb = 1'b0;
        #1;
        check("R10 error follows read strobe", {15'd0, rd_err}, 16'h0000);
        sel_valid = 1'b1; sel_setup = 1'b1; sel_ep = 2'd0; rd_stb = 1'b1;
        #1;
        check("R11 set-up select gives zero", rd_data, 16'h0000);
        check("R11 set-up select no error", {15'd0, rd_err}, 16'h0000);
        arm_stb = 1'b1;
        tick();
        arm_stb = 1'b0; rd_stb = 1'b0; sel_setup = 1'b0; sel_valid = 1'b0;
        read_ep(2'd0, v); check("R11 arm on set-up ignored", v, 16'h0002);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        t_reset_state();
        t_arm_and_handshakes();
        t_fill_and_drain();
        t_underflow_and_flush();
        t_select_rules();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1-run hung: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule